// File: doc/BRIEF.md
# Serial Register Slave for a 4x4 Crosspoint Switch

This block is the two-wire serial slave that holds the configuration of a four-input, four-output crosspoint switch. A host on the bus clock and data lines (SCL and SDA) can write the routing byte and the control byte, and read back those bytes together with a status byte that shows which of the four inputs carries a valid signal. SDA is open-drain. The block never drives it high: it only pulls the line low through `sda_oe`, and `sda_o` stays tied low.

Both bus lines are brought into the system clock domain through two-flop synchronisers. The system clock must run at least eight times faster than SCL. START, STOP and the SCL edges are found by comparing the synchronised samples with their values one cycle earlier. The 7-bit device address is a fixed `101` prefix in the upper bits followed by four strap pins, so sixteen of these slaves can share one bus. The routing byte (register 0x00) and the control byte (register 0x03) drive the switch fabric directly through `xbar_sel` and `ctrl_out`.

The interface only responds while `bus_en` is high. Every change of level on that pin, rising or falling, puts all registers back to their reset values.

Top module: `smbr_slave`

## Requirements
- R1: After reset, `xbar_sel` is 0x00, `ctrl_out` is 0x0F and SDA is released (`sda_oe` = 0).
- R2: The slave acknowledges (pulls SDA low in the ninth bit) an address byte whose upper seven bits, MSB first, equal 1,0,1,strap[3],strap[2],strap[1],strap[0]. Any other address gets a NACK, and the slave ignores every byte that follows until the next START.
- R3: A write transfer is an address byte with bit 0 = 0, then a pointer byte, then data bytes. Each data byte is stored at the pointer and the pointer then advances by one, so consecutive data bytes land at consecutive registers. Register 0x00 drives `xbar_sel` and register 0x03 drives `ctrl_out`.
- R4: A read is a pointer write followed by a repeated START and an address byte with bit 0 = 1. The slave then shifts out the register at the pointer, MSB first. Each ACK from the master advances the pointer and sends the next register. A NACK ends the read and releases SDA.
- R5: Register 0x04 reads as {4'b0000, sig_ok[3:0]}: bit n is 1 when input n carries a valid signal. Writes to register 0x04 are acknowledged but change no register.
- R6: Writes to any address other than 0x00, 0x03 and 0x04 are acknowledged and discarded. Reads from those addresses return 0x00.
- R7: Any change of level on `bus_en` returns registers 0x00 and 0x03 to 0x00 and 0x0F.
- R8: While `bus_en` is low, the slave never pulls SDA low and no register can be written.
- R9: A STOP or a START arriving part way through a byte abandons that byte, and the bits received so far are not stored. After a START, the next byte is taken as a new address.
- R10: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Serial interface enable; every level change clears the registers |
| strap | input | 4 | Low four bits of the device address |
| sig_ok | input | 4 | Per-input valid-signal flags shown in register 0x04 |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_o | output | 1 | Data value driven when enabled, always 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| xbar_sel | output | 8 | Routing byte, two select bits per output, output 0 in bits [1:0] |
| ctrl_out | output | 8 | Control byte |

## Verification
Some properties are checked by the assertions on every cycle: SDA is never pulled while the interface is disabled and starts being pulled only with SCL low; a clear pulse restores both register reset values; a write strobe to the routing register lands on the next cycle; a write strobe aimed at the status register leaves the writable registers untouched. Other behaviour can only be shown by the bench's bus transfers: address matching across every strap value, pointer auto-increment on writes and reads, repeated-start reads, reads of unimplemented addresses, and abandonment of partial bytes by STOP or START.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = 4;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_RXACK,
        LK_TX,
        LK_TXACK,
        LK_SKIP
    } link_st_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_PTR,
        BK_DATA
    } byte_kind_e;

    typedef struct packed {
        link_st_e          st;
        byte_kind_e        kind;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] ptr;
        logic              rd;
        logic              mack;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
    } link_s;

    typedef struct packed {
        logic [BYTE_W-1:0] sw;
        logic [BYTE_W-1:0] ctl;
        logic              en_p;
    } regs_s;

endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/smbr_regfile.sv
module smbr_regfile
    import smbr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SW_ADDR   = 8'h00,
    parameter logic [BYTE_W-1:0] CTL_ADDR  = 8'h03,
    parameter logic [BYTE_W-1:0] STAT_ADDR = 8'h04,
    parameter logic [BYTE_W-1:0] SW_RST    = 8'h00,
    parameter logic [BYTE_W-1:0] CTL_RST   = 8'h0F,
    parameter int unsigned       NIN       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              we,
    input  logic [BYTE_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] raddr,
    input  logic [NIN-1:0]    sig_ok,
    output logic [BYTE_W-1:0] rdata,
    output logic              clr,
    output logic [BYTE_W-1:0] sw_cfg,
    output logic [BYTE_W-1:0] ctl_cfg
);

    localparam int unsigned PAD_W = BYTE_W - NIN;

    regs_s r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.en_p = bus_en;
        clr      = bus_en ^ r_q.en_p;
        if (clr) begin
            r_d.sw  = SW_RST;
            r_d.ctl = CTL_RST;
        end else if (we) begin
            if (waddr == SW_ADDR)  r_d.sw  = wdata;
            if (waddr == CTL_ADDR) r_d.ctl = wdata;
        end
    end

    always_comb begin
        unique case (raddr)
            SW_ADDR:   rdata = r_q.sw;
            CTL_ADDR:  rdata = r_q.ctl;
            STAT_ADDR: rdata = {{PAD_W{1'b0}}, sig_ok};
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sw: SW_RST, ctl: CTL_RST, en_p: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sw_cfg  = r_q.sw;
    assign ctl_cfg = r_q.ctl;

endmodule

// File: rtl/smbr_link.sv
module smbr_link
    import smbr_pkg::*;
#(
    parameter logic [2:0]  PREFIX = 3'b101,
    parameter int unsigned STRAP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rdata,
    output logic [BYTE_W-1:0]  ptr,
    output logic               we,
    output logic [BYTE_W-1:0]  waddr,
    output logic [BYTE_W-1:0]  wdata,
    output logic               sda_oe
);

    localparam int unsigned          DEV_W   = 3 + STRAP_W;
    localparam logic [CNT_W-1:0]     LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]     LAST_TX = CNT_W'(BYTE_W - 1);

    link_s q, d;
    logic  scl_rise, scl_fall, start_ev, stop_ev;
    logic  [DEV_W-1:0] dev_id;

    always_comb begin
        dev_id   = {PREFIX, strap};
        scl_rise = scl_s & ~q.scl_p;
        scl_fall = ~scl_s & q.scl_p;
        start_ev = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_ev  = scl_s & q.scl_p & ~q.sda_p & sda_s;

        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
        we      = 1'b0;
        waddr   = q.ptr;
        wdata   = q.sh;

        if (!enable) begin
            d.st  = LK_IDLE;
            d.oe  = 1'b0;
            d.ptr = '0;
        end else if (start_ev) begin
            d.st   = LK_RX;
            d.kind = BK_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
        end else if (stop_ev) begin
            d.st = LK_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                LK_RX: begin
                    if (scl_rise && q.cnt != LAST_RX) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_RX) begin
                        d.cnt = '0;
                        unique case (q.kind)
                            BK_ADDR: begin
                                if (q.sh[BYTE_W-1:1] == dev_id) begin
                                    d.rd = q.sh[0];
                                    d.oe = 1'b1;
                                    d.st = LK_RXACK;
                                end else begin
                                    d.st = LK_SKIP;
                                end
                            end
                            BK_PTR: begin
                                d.ptr = q.sh;
                                d.oe  = 1'b1;
                                d.st  = LK_RXACK;
                            end
                            default: begin
                                we    = 1'b1;
                                d.ptr = q.ptr + 1'b1;
                                d.oe  = 1'b1;
                                d.st  = LK_RXACK;
                            end
                        endcase
                    end
                end
                LK_RXACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.kind == BK_ADDR && q.rd) begin
                            d.st = LK_TX;
                            d.sh = rdata;
                            d.oe = ~rdata[BYTE_W-1];
                        end else begin
                            d.st   = LK_RX;
                            d.oe   = 1'b0;
                            d.kind = (q.kind == BK_ADDR) ? BK_PTR : BK_DATA;
                        end
                    end
                end
                LK_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_TX) begin
                            d.oe = 1'b0;
                            d.st = LK_TXACK;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.cnt = q.cnt + 1'b1;
                            d.oe  = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                LK_TXACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                        if (!sda_s) d.ptr = q.ptr + 1'b1;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.st = LK_TX;
                            d.sh = rdata;
                            d.oe = ~rdata[BYTE_W-1];
                        end else begin
                            d.st = LK_SKIP;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: LK_IDLE, kind: BK_ADDR, cnt: '0, sh: '0, ptr: '0,
                   rd: 1'b0, mack: 1'b0, oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign ptr    = q.ptr;
    assign sda_oe = q.oe;

endmodule

// File: rtl/smbr_slave.sv
module smbr_slave
    import smbr_pkg::*;
#(
    parameter logic [2:0]  PREFIX  = 3'b101,
    parameter int unsigned STRAP_W = 4,
    parameter int unsigned NIN     = 4,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic [STRAP_W-1:0] strap,
    input  logic [NIN-1:0]     sig_ok,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_o,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  xbar_sel,
    output logic [BYTE_W-1:0]  ctrl_out
);

    logic [1:0]        lines_s;
    logic              scl_s, sda_s;
    logic [BYTE_W-1:0] ptr, rdata, waddr, wdata;
    logic              we, clr;

    smbr_sync #(.LINES(2), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .sync_o (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    smbr_link #(.PREFIX(PREFIX), .STRAP_W(STRAP_W)) u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (bus_en),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .strap  (strap),
        .rdata  (rdata),
        .ptr    (ptr),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .sda_oe (sda_oe)
    );

    smbr_regfile #(.NIN(NIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_en  (bus_en),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr   (ptr),
        .sig_ok  (sig_ok),
        .rdata   (rdata),
        .clr     (clr),
        .sw_cfg  (xbar_sel),
        .ctl_cfg (ctrl_out)
    );

    assign sda_o = 1'b0;

endmodule

// File: rtl/smbr_checker.sv
module smbr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_en,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       clr,
    input logic       we,
    input logic [7:0] waddr,
    input logic [7:0] wdata,
    input logic [7:0] xbar_sel,
    input logic [7:0] ctrl_out
);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_released_in_reset: assert (sda_oe == 1'b0);
        end
    end

    a_r8_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !sda_oe);

    a_r8_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> !we);

    a_r7_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (xbar_sel == 8'h00 && ctrl_out == 8'h0F));

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && waddr == 8'h00) |=> xbar_sel == $past(wdata));

    a_r5_status_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && waddr == 8'h04) |=> ($stable(xbar_sel) && $stable(ctrl_out)));

    a_r10_pull_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

endmodule

bind smbr_slave smbr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .sda_oe   (sda_oe),
    .scl_s    (scl_s),
    .clr      (clr),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .xbar_sel (xbar_sel),
    .ctrl_out (ctrl_out)
);

// File: tb/test_smbr_slave.sv
module test_smbr_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic [3:0] strap = 4'h0;
    logic [3:0] sig_ok = 4'h0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_o, sda_oe;
    logic [7:0] xbar_sel, ctrl_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int off_drive = 0;
    int bad_rise = 0;
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smbr_slave i_smbr_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .strap    (strap),
        .sig_ok   (sig_ok),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .xbar_sel (xbar_sel),
        .ctrl_out (ctrl_out)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!bus_en && sda_oe) off_drive++;
        if (sda_oe && !oe_prev && scl) bad_rise++;
        oe_prev = sda_oe;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl = 1'b1;   qw();
        sda_m = 1'b0; qw();
        scl = 1'b0;   qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl = 1'b1;   qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qw();
            scl = 1'b1; qw(); qw();
            scl = 1'b0; qw();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; qw();
        scl = 1'b1;   qw();
        ack = sda_line; qw();
        scl = 1'b0;   qw();
    endtask

    task automatic recv_byte(input logic mbit, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            scl = 1'b1; qw();
            b[i] = sda_line; qw();
            scl = 1'b0; qw();
        end
        sda_m = mbit; qw();
        scl = 1'b1; qw(); qw();
        scl = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    localparam logic [7:0] DEV_W = {3'b101, 4'hA, 1'b0};
    localparam logic [7:0] DEV_R = {3'b101, 4'hA, 1'b1};

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
        logic k;
        bus_start();
        send_byte(DEV_W, k);
        send_byte(a, k);
        send_byte(v, k);
        bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        logic k;
        bus_start();
        send_byte(DEV_W, k);
        send_byte(a, k);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b1, v);
        bus_stop();
    endtask

    initial begin
        logic       k;
        logic [7:0] v;
        logic [6:0] adr;

        repeat (5) @(negedge clk);
        chk("R1 xbar reset", xbar_sel, 8'h00);
        chk("R1 ctrl reset", ctrl_out, 8'h0F);
        chk("R1 sda released", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 xbar after enable", xbar_sel, 8'h00);

        // R2: strap sweep, matching address and four single-bit mismatches
        for (int s = 0; s < 16; s++) begin
            strap = 4'(s);
            for (int m = 0; m < 5; m++) begin
                adr = {3'b101, (m == 0) ? 4'(s) : 4'(s) ^ 4'(1 << (m - 1))};
                bus_start();
                send_byte({adr, 1'b0}, k);
                bus_stop();
                chk("R2 address ack", {7'd0, k}, (m == 0) ? 8'h00 : 8'h01);
            end
        end
        strap = 4'hA;
        bus_start();
        send_byte({3'b100, 4'hA, 1'b0}, k);
        bus_stop();
        chk("R2 wrong prefix nack", {7'd0, k}, 8'h01);
        bus_start();
        send_byte({3'b101, 4'h5, 1'b0}, k);
        send_byte(8'h00, k);
        chk("R2 ignored byte nack", {7'd0, k}, 8'h01);
        send_byte(8'h55, k);
        bus_stop();
        chk("R2 ignored write", xbar_sel, 8'h00);

        // R3: value sweep on the routing register
        for (int i = 0; i < 16; i++) begin
            wr_reg(8'h00, 8'((i * 8'h11) ^ 8'h3C));
            chk("R3 routing write", xbar_sel, 8'((i * 8'h11) ^ 8'h3C));
        end
        // R3: auto-increment across 0..3, 0x01/0x02 discarded
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h00, k);
        send_byte(8'hA5, k);
        send_byte(8'h11, k);
        chk("R6 unimplemented write ack", {7'd0, k}, 8'h00);
        send_byte(8'h22, k);
        send_byte(8'hC3, k);
        bus_stop();
        chk("R3 burst reg0", xbar_sel, 8'hA5);
        chk("R3 burst reg3", ctrl_out, 8'hC3);

        // R5: write to status register acked and discarded
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h04, k);
        send_byte(8'hFF, k);
        bus_stop();
        chk("R5 status write ack", {7'd0, k}, 8'h00);
        chk("R5 status write no effect ctrl", ctrl_out, 8'hC3);
        chk("R5 status write no effect xbar", xbar_sel, 8'hA5);

        // R4: burst read 0..4 with repeated start
        sig_ok = 4'b1010;
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h00, k);
        bus_start();
        send_byte(DEV_R, k);
        chk("R4 read address ack", {7'd0, k}, 8'h00);
        recv_byte(1'b0, v); chk("R4 read reg0", v, 8'hA5);
        recv_byte(1'b0, v); chk("R4 read reg1", v, 8'h00);
        recv_byte(1'b0, v); chk("R4 read reg2", v, 8'h00);
        recv_byte(1'b0, v); chk("R4 read reg3", v, 8'hC3);
        recv_byte(1'b1, v); chk("R4 read reg4", v, 8'h0A);
        bus_stop();
        chk("R4 released after nack", {7'd0, sda_oe}, 8'h00);

        // R5: status sweep
        for (int i = 0; i < 16; i++) begin
            sig_ok = 4'(i);
            rd_reg(8'h04, v);
            chk("R5 status read", v, 8'(i));
        end

        // R6: unimplemented addresses
        rd_reg(8'h05, v); chk("R6 read 0x05", v, 8'h00);
        rd_reg(8'h07, v); chk("R6 read 0x07", v, 8'h00);
        rd_reg(8'hFF, v); chk("R6 read 0xFF", v, 8'h00);
        wr_reg(8'h07, 8'h99);
        rd_reg(8'h00, v); chk("R6 write 0x07 no effect reg0", v, 8'hA5);
        rd_reg(8'h03, v); chk("R6 write 0x07 no effect reg3", v, 8'hC3);

        // R9: STOP inside a data byte
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h00, k);
        send_bits(8'hFF, 4);
        bus_stop();
        chk("R9 stop mid-byte", xbar_sel, 8'hA5);
        // R9: START inside a data byte, then a fresh transfer
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h00, k);
        send_bits(8'h0F, 3);
        bus_start();
        send_byte(DEV_W, k);
        chk("R9 restart address ack", {7'd0, k}, 8'h00);
        send_byte(8'h00, k);
        send_byte(8'h5A, k);
        bus_stop();
        chk("R9 restart write", xbar_sel, 8'h5A);

        // R7 / R8: disable clears registers and silences the slave
        bus_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 clear on fall reg0", xbar_sel, 8'h00);
        chk("R7 clear on fall reg3", ctrl_out, 8'h0F);
        bus_start();
        send_byte(DEV_W, k);
        chk("R8 nack while off", {7'd0, k}, 8'h01);
        send_byte(8'h00, k);
        send_byte(8'h77, k);
        bus_stop();
        chk("R8 no write while off", xbar_sel, 8'h00);
        chk("R8 never driven while off", 8'(off_drive), 8'h00);
        bus_en = 1'b1;
        repeat (3) @(negedge clk);
        wr_reg(8'h03, 8'h81);
        chk("R7 usable after re-enable", ctrl_out, 8'h81);
        chk("R10 pull starts only with scl low", 8'(bad_rise), 8'h00);

        summary();
        $finish;
    end

endmodule